// File: doc/BRIEF.md
# Vector Element Extract-Insert Unit

The unit takes an old destination vector and a source vector and returns the destination with a single element replaced by one chosen element of the source. Elements are 8, 16, 32 or 64 bits wide. An 8-bit immediate selects both positions: its high nibble names the destination slot to overwrite and its low nibble names the source element to copy. Each nibble is cut down to the number of elements that fit in a 128-bit lane at the chosen width.

Operands are up to 256 bits. In 256-bit operation the two 128-bit lanes are treated as separate vectors. Each lane performs the same copy using the same lane-relative positions. In 128-bit operation only the low lane is produced and the upper half of the result is cleared.

Operands enter on a valid/ready stream and leave through a single registered stage on a second valid/ready stream. An input is taken in a cycle where `in_valid` and `in_ready` are both high, and its result is presented in the following cycle. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the presented result is held without change. Back-pressure therefore stalls the input side within the same cycle.

Top module: `vec_extract_insert`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: An input is accepted when `in_valid` and `in_ready` are both high, where `in_ready` = not `out_valid` or `out_ready`. Its result appears with `out_valid` high on the next cycle.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R4: `in_ew` selects the element width: 0 = 8 bits, 1 = 16, 2 = 32, 3 = 64. The insert index is `in_imm[7:4]` and the extract index is `in_imm[3:0]`. Both indices are ANDed with 0xF, 0x7, 0x3 or 0x1 respectively for those widths, so immediate bits above the mask have no effect.
- R5: In the low lane (bits 127:0), result element `ins` equals source element `extr` of the low lane.
- R6: Every result element that is not an inserted one equals the corresponding element of `in_dst`.
- R7: With `in_wide` = 1, the upper lane (bits 255:128) writes element `ins` + max from source element `extr` + max, where max = 128 / element width. The rest of that lane is taken from `in_dst`.
- R8: With `in_wide` = 0, result bits 255:128 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set is valid |
| in_ready | output | 1 | Unit can accept an operand set |
| in_dst | input | 256 | Old destination vector |
| in_src | input | 256 | Source vector |
| in_imm | input | 8 | Insert index (high nibble), extract index (low nibble) |
| in_ew | input | 2 | Element width code |
| in_wide | input | 1 | 1 = 256-bit operation, 0 = 128-bit |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 256 | Result vector |

## Verification
The assertions assume that `in_ew`, `in_imm` and `in_wide` are known values whenever `in_valid` is high. They also assume the consumer may drop `out_ready` at any time, while the producer never changes operands that have already been accepted. The checker keeps its own copy of each accepted operand set, so producer behaviour after the handshake does not matter to it. The stimulus holds all operand fields steady from the falling edge until acceptance. It sweeps every immediate under every width in both lane modes and toggles `out_ready` pseudo-randomly so that stalls occur both with and without a pending input.

// File: rtl/eins_pkg.sv
package eins_pkg;
  typedef enum logic [1:0] {
    EW_BYTE = 2'd0,
    EW_HALF = 2'd1,
    EW_WORD = 2'd2,
    EW_DBL  = 2'd3
  } ew_e;

  localparam int LANE_W = 128;
  localparam int OFF_W  = $clog2(LANE_W);
endpackage

// File: rtl/eins_decode.sv
module eins_decode
  import eins_pkg::*;
(
  input  logic [7:0]        imm,
  input  ew_e               ew,
  output logic [OFF_W-1:0]  ins_off,
  output logic [OFF_W-1:0]  ext_off,
  output logic [LANE_W-1:0] elem_mask
);
  logic [3:0] idx_mask;
  logic [3:0] ins_idx;
  logic [3:0] ext_idx;

  always_comb begin
    unique case (ew)
      EW_BYTE: begin idx_mask = 4'hF; elem_mask = {{(LANE_W-8){1'b0}},  {8{1'b1}}};  end
      EW_HALF: begin idx_mask = 4'h7; elem_mask = {{(LANE_W-16){1'b0}}, {16{1'b1}}}; end
      EW_WORD: begin idx_mask = 4'h3; elem_mask = {{(LANE_W-32){1'b0}}, {32{1'b1}}}; end
      default: begin idx_mask = 4'h1; elem_mask = {{(LANE_W-64){1'b0}}, {64{1'b1}}}; end
    endcase
    ins_idx = imm[7:4] & idx_mask;
    ext_idx = imm[3:0] & idx_mask;
    // bit offset = index * 8 * 2^ew; masked index keeps this below LANE_W
    ins_off = OFF_W'({ins_idx, 3'b000}) << ew;
    ext_off = OFF_W'({ext_idx, 3'b000}) << ew;
  end
endmodule

// File: rtl/eins_lane.sv
module eins_lane
  import eins_pkg::*;
(
  input  logic              lane_en,
  input  logic [LANE_W-1:0] dst,
  input  logic [LANE_W-1:0] src,
  input  logic [OFF_W-1:0]  ins_off,
  input  logic [OFF_W-1:0]  ext_off,
  input  logic [LANE_W-1:0] elem_mask,
  output logic [LANE_W-1:0] res
);
  logic [LANE_W-1:0] picked;
  logic [LANE_W-1:0] placed;
  logic [LANE_W-1:0] hole;

  always_comb begin
    picked = (src >> ext_off) & elem_mask;
    placed = picked << ins_off;
    hole   = ~(elem_mask << ins_off);
    res    = lane_en ? ((dst & hole) | placed) : '0;
  end
endmodule

// File: rtl/eins_stage.sv
module eins_stage #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (up_valid && up_ready) dn_data <= up_data;
  end
endmodule

// File: rtl/vec_extract_insert.sv
module vec_extract_insert
  import eins_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [VLEN-1:0] in_dst,
  input  logic [VLEN-1:0] in_src,
  input  logic [7:0]      in_imm,
  input  logic [1:0]      in_ew,
  input  logic            in_wide,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VLEN-1:0] out_data
);
  localparam int NLANES = VLEN / LANE_W;

  logic [OFF_W-1:0]  ins_off;
  logic [OFF_W-1:0]  ext_off;
  logic [LANE_W-1:0] elem_mask;
  logic [VLEN-1:0]   merged;

  eins_decode u_dec (
    .imm       (in_imm),
    .ew        (ew_e'(in_ew)),
    .ins_off   (ins_off),
    .ext_off   (ext_off),
    .elem_mask (elem_mask)
  );

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    logic en;
    assign en = (l == 0) || in_wide;
    eins_lane u_lane (
      .lane_en   (en),
      .dst       (in_dst[l*LANE_W +: LANE_W]),
      .src       (in_src[l*LANE_W +: LANE_W]),
      .ins_off   (ins_off),
      .ext_off   (ext_off),
      .elem_mask (elem_mask),
      .res       (merged[l*LANE_W +: LANE_W])
    );
  end

  eins_stage #(.W(VLEN)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (merged),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_data)
  );
endmodule

// File: rtl/eins_checker.sv
module eins_checker #(
  parameter int VLEN = 256
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [VLEN-1:0] in_dst,
  input logic [VLEN-1:0] in_src,
  input logic [7:0]      in_imm,
  input logic [1:0]      in_ew,
  input logic            in_wide,
  input logic            out_valid,
  input logic            out_ready,
  input logic [VLEN-1:0] out_data
);
  logic [VLEN-1:0] c_dst;
  logic [VLEN-1:0] c_src;
  logic            c_wide;
  logic [3:0]      c_ins_b;
  logic [3:0]      c_ext_b;
  logic [3:0]      lim;

  always_comb lim = 4'(16 >> in_ew) - 4'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_dst <= '0; c_src <= '0; c_wide <= 1'b0; c_ins_b <= '0; c_ext_b <= '0;
    end else if (in_valid && in_ready) begin
      c_dst   <= in_dst;
      c_src   <= in_src;
      c_wide  <= in_wide;
      c_ins_b <= 4'((in_imm[7:4] & lim) << in_ew);
      c_ext_b <= 4'((in_imm[3:0] & lim) << in_ew);
    end
  end

  assert_ready_when_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  assert_valid_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  assert_hold_under_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  assert_insert_first_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[c_ins_b*8 +: 8] == c_src[c_ext_b*8 +: 8]));
  assert_keep_low_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && c_ins_b != 4'd0) |-> (out_data[7:0] == c_dst[7:0]));
  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !c_wide) |-> (out_data[VLEN-1:128] == '0));
endmodule

bind vec_extract_insert eins_checker #(.VLEN(VLEN)) u_chk (.*);

// File: tb/vec_extract_insert_bench.sv
module vec_extract_insert_bench;
  localparam int CLK_P = 10;
  localparam int VL = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [VL-1:0] in_dst = '0;
  logic [VL-1:0] in_src = '0;
  logic [7:0]    in_imm = '0;
  logic [1:0]    in_ew = '0;
  logic          in_wide = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [VL-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [VL-1:0] expq[$];
  logic          driving_done = 1'b0;
  logic          finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  vec_extract_insert u_vec_extract_insert (.*);

  function automatic logic [VL-1:0] model(input logic [VL-1:0] d, input logic [VL-1:0] s,
                                          input logic [7:0] imm, input logic [1:0] ew,
                                          input logic wide);
    logic [VL-1:0] r;
    int eb, mx, ins, ex;
    eb  = 1 << ew;
    mx  = 16 / eb;
    ins = int'(imm[7:4]) % mx;
    ex  = int'(imm[3:0]) % mx;
    r = d;
    if (!wide) r[VL-1:128] = '0;
    for (int ln = 0; ln < (wide ? 2 : 1); ln++)
      for (int k = 0; k < eb; k++)
        r[(ln*16 + ins*eb + k)*8 +: 8] = s[(ln*16 + ex*eb + k)*8 +: 8];
    return r;
  endfunction

  function automatic logic [VL-1:0] rnd_vec();
    logic [VL-1:0] v;
    for (int i = 0; i < VL/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [VL-1:0] act,
                       input logic [VL-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic send(input logic [VL-1:0] d, input logic [VL-1:0] s,
                      input logic [7:0] imm, input logic [1:0] ew, input logic wide);
    @(negedge clk);
    in_valid = 1'b1; in_dst = d; in_src = s; in_imm = imm; in_ew = ew; in_wide = wide;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    expq.push_back(model(d, s, imm, ew, wide));
    @(posedge clk);
    #1;
    // R2: accepted item shows up on the next cycle
    check(out_valid === 1'b1, "R2 valid after accept", VL'(out_valid), VL'(1));
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  initial begin
    logic          stalled;
    logic [VL-1:0] held;
    stalled = 1'b0;
    held = '0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (stalled) begin
        check(out_valid === 1'b1 && out_data === held, "R3 hold under stall", out_data, held);
      end
      out_ready = ($urandom % 4) != 0;
      if (!out_valid) check(in_ready === 1'b1, "R2 ready when empty", VL'(in_ready), VL'(1));
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R2 unexpected output", out_data, '0);
        end else begin
          logic [VL-1:0] e;
          e = expq.pop_front();
          check(out_data[127:0] === e[127:0], "R4 R5 R6 low lane", out_data, e);
          check(out_data[VL-1:128] === e[VL-1:128], "R7 R8 upper lane", out_data, e);
        end
      end
      stalled = out_valid && !out_ready;
      held = out_data;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // Driver
  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid === 1'b0, "R1 out_valid in reset", VL'(out_valid), VL'(0));
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid === 1'b0 && in_ready === 1'b1, "R1 idle after reset",
          VL'({out_valid, in_ready}), VL'(2'b01));
    // R4 R5 R6 R7 R8: every immediate, width and lane mode
    for (int w = 0; w < 2; w++)
      for (int e = 0; e < 4; e++)
        for (int im = 0; im < 256; im++)
          send(rnd_vec(), rnd_vec(), 8'(im), 2'(e), w[0]);
    // Corner: all-ones destination with zero source, 64-bit top slot
    send('1, '0, 8'hF1, 2'd3, 1'b1);
    send('0, '1, 8'h00, 2'd0, 1'b0);
    driving_done = 1'b1;
    while (expq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule